// File: doc/BRIEF.md
# Sponge-Style AEAD Mode Controller

This block is the mode-of-operation datapath placed around a 128-bit forward block cipher to build authenticated encryption. It owns the single 128-bit chaining state and nothing else. A small command set changes that state with XOR or overwrite only. The commands cover absorbing a 64-bit associated-data or message block, loading a block with no feedback, absorbing a 120-bit nonce, absorbing a ciphertext block during decryption, and emitting the state as a tag. Every absorb-type command is followed by one call to an external cipher through a start/done handshake. The cipher's result then replaces the state.

The 64-bit rate is the upper half of the state, bits 127:64. In encryption the returned word is the old rate XOR the message. In decryption the returned word is the old rate XOR the ciphertext, and the ciphertext then overwrites the rate. Encryption and decryption therefore drive the state through identical values, and the tags match. Each block is read once, so there is no buffering and no inverse cipher.

Top module: `aead_mode_ctrl`

## Requirements
- R1: After synchronous reset the state is all zero, `busy` and `cph_start` are low, `cmd_ready` is high, and neither `out_valid` nor `tag_valid` is asserted.
- R2: Opcode 3'd1 (absorb) XORs `blk_in` into state bits 127:64. One cycle after acceptance it pulses `out_valid` with `out_data` equal to the old bits 127:64 XOR `blk_in`.
- R3: Opcode 3'd2 (load) overwrites state bits 127:64 with `blk_in`, leaves bits 63:0 unchanged, and produces no `out_valid`.
- R4: Opcode 3'd3 (nonce) XORs `nonce_in` into state bits 127:8 and XORs the domain constant 8'h01 into bits 7:0.
- R5: Opcode 3'd4 (ciphertext absorb) pulses `out_valid` one cycle after acceptance with `out_data` equal to the old bits 127:64 XOR `blk_in`, and then overwrites bits 127:64 with `blk_in`.
- R6: Opcode 3'd5 (tag) pulses `tag_valid` one cycle after acceptance with `tag_out` equal to the full 128-bit state. It does not change the state and starts no cipher call.
- R7: Opcodes 1 to 4 each pulse `cph_start` high for exactly one cycle, in the cycle after acceptance, with `cph_din` equal to the updated state.
- R8: `busy` is high and `cmd_ready` low from the cycle after an absorb-type command is accepted until the cycle after `cph_done`. Any command presented while `busy` is high is ignored.
- R9: When `cph_done` is high while waiting, the state is replaced by `cph_dout`.
- R10: Opcodes 0, 6 and 7 are ignored: no state change, no cipher call, no output pulse.
- R11: Encrypting messages and then absorbing the resulting ciphertexts, under the same nonce and from reset, returns the original messages and an identical tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command opcode |
| blk_in | input | 64 | Data, message or ciphertext block |
| nonce_in | input | 120 | Nonce for the nonce command |
| cmd_ready | output | 1 | High when a command can be accepted |
| busy | output | 1 | Cipher call in progress |
| out_valid | output | 1 | One-cycle pulse: out_data valid |
| out_data | output | 64 | Ciphertext or plaintext word |
| tag_valid | output | 1 | One-cycle pulse: tag_out valid |
| tag_out | output | 128 | Authentication tag |
| cph_start | output | 1 | One-cycle cipher start request |
| cph_din | output | 128 | State handed to the cipher |
| cph_done | input | 1 | Cipher result valid |
| cph_dout | input | 128 | Cipher result |

## Verification
The assertions assume that the cipher port asserts `cph_done` only while the controller is waiting. In particular, it never asserts `cph_done` in the cycle when `cph_start` is high, and it gives exactly one done per start. The bench's stand-in permutation meets this by answering two cycles after it sees a start pulse, holding done for one cycle, and starting nothing else. Commands are issued only once the stimulus has seen `busy` low, except for one deliberate command presented while busy, which checks that it is ignored.

// File: rtl/aead_pkg.sv
package aead_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ABSORB  = 3'd1,
        OP_LOAD    = 3'd2,
        OP_NONCE   = 3'd3,
        OP_CTEXT   = 3'd4,
        OP_TAG     = 3'd5
    } op_e;

    // Per-command control flags
    typedef struct packed {
        logic known;  // legal opcode
        logic upd;    // state is rewritten on accept
        logic call;   // cipher call follows
        logic emit;   // a data word is returned
        logic tag;    // the full state is returned
    } op_ctl_t;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_CALL = 2'd1,
        CS_WAIT = 2'd2
    } call_st_e;

    function automatic op_ctl_t decode_op(input logic [2:0] op);
        op_ctl_t c;
        c = '0;
        case (op)
            OP_ABSORB: c = '{known: 1'b1, upd: 1'b1, call: 1'b1, emit: 1'b1, tag: 1'b0};
            OP_LOAD:   c = '{known: 1'b1, upd: 1'b1, call: 1'b1, emit: 1'b0, tag: 1'b0};
            OP_NONCE:  c = '{known: 1'b1, upd: 1'b1, call: 1'b1, emit: 1'b0, tag: 1'b0};
            OP_CTEXT:  c = '{known: 1'b1, upd: 1'b1, call: 1'b1, emit: 1'b1, tag: 1'b0};
            OP_TAG:    c = '{known: 1'b1, upd: 1'b0, call: 1'b0, emit: 1'b0, tag: 1'b1};
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/aead_cmd_decode.sv
module aead_cmd_decode
    import aead_pkg::*;
#(
    parameter int STATE_W = 128,
    parameter int BLK_W   = 64,
    parameter int NONCE_W = 120,
    parameter int PAD_W   = STATE_W - NONCE_W,
    parameter logic [PAD_W-1:0] PAD_CONST = 'h01
) (
    input  logic [2:0]         op,
    input  logic [STATE_W-1:0] state,
    input  logic [BLK_W-1:0]   blk,
    input  logic [NONCE_W-1:0] nonce,
    output op_ctl_t            ctl,
    output logic [STATE_W-1:0] nxt_state,
    output logic [BLK_W-1:0]   out_word
);
    localparam int CAP_W = STATE_W - BLK_W;

    logic [BLK_W-1:0]   rate_old;
    logic [CAP_W-1:0]   cap_old;
    logic [STATE_W-1:0] nonce_mix;

    assign rate_old  = state[STATE_W-1 -: BLK_W];
    assign cap_old   = state[CAP_W-1:0];
    assign ctl       = decode_op(op);
    assign nonce_mix = {nonce, PAD_CONST};

    always_comb begin
        nxt_state = state;
        out_word  = rate_old ^ blk;
        case (op)
            OP_ABSORB: nxt_state = {rate_old ^ blk, cap_old};
            OP_LOAD:   nxt_state = {blk, cap_old};
            OP_NONCE:  nxt_state = state ^ nonce_mix;
            OP_CTEXT:  nxt_state = {blk, cap_old};
            default:   nxt_state = state;
        endcase
    end

endmodule

// File: rtl/aead_call_fsm.sv
module aead_call_fsm
    import aead_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic done,
    output logic start,
    output logic busy,
    output logic waiting
);
    call_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            CS_IDLE: if (launch) st_d = CS_CALL;
            CS_CALL: st_d = CS_WAIT;
            CS_WAIT: if (done) st_d = CS_IDLE;
            default: st_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CS_IDLE;
        else     st_q <= st_d;
    end

    assign start   = (st_q == CS_CALL);
    assign busy    = (st_q != CS_IDLE);
    assign waiting = (st_q == CS_WAIT);

endmodule

// File: rtl/aead_mode_ctrl.sv
module aead_mode_ctrl
    import aead_pkg::*;
#(
    parameter int STATE_W = 128,
    parameter int BLK_W   = 64,
    parameter int NONCE_W = 120,
    parameter logic [STATE_W-NONCE_W-1:0] PAD_CONST = 'h01
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [BLK_W-1:0]   blk_in,
    input  logic [NONCE_W-1:0] nonce_in,
    output logic               cmd_ready,
    output logic               busy,
    output logic               out_valid,
    output logic [BLK_W-1:0]   out_data,
    output logic               tag_valid,
    output logic [STATE_W-1:0] tag_out,
    output logic               cph_start,
    output logic [STATE_W-1:0] cph_din,
    input  logic               cph_done,
    input  logic [STATE_W-1:0] cph_dout
);
    localparam int PAD_W = STATE_W - NONCE_W;

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] nxt_state;
    logic [BLK_W-1:0]   out_word;
    op_ctl_t            ctl;
    logic               accept;
    logic               waiting;

    aead_cmd_decode #(
        .STATE_W  (STATE_W),
        .BLK_W    (BLK_W),
        .NONCE_W  (NONCE_W),
        .PAD_W    (PAD_W),
        .PAD_CONST(PAD_CONST)
    ) u_dec (
        .op       (cmd_op),
        .state    (state_q),
        .blk      (blk_in),
        .nonce    (nonce_in),
        .ctl      (ctl),
        .nxt_state(nxt_state),
        .out_word (out_word)
    );

    assign accept = cmd_valid && !busy && ctl.known;

    aead_call_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .launch (accept && ctl.call),
        .done   (cph_done),
        .start  (cph_start),
        .busy   (busy),
        .waiting(waiting)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            tag_valid <= 1'b0;
            tag_out   <= '0;
        end else begin
            out_valid <= accept && ctl.emit;
            tag_valid <= accept && ctl.tag;
            if (accept && ctl.emit) out_data <= out_word;
            if (accept && ctl.tag)  tag_out  <= state_q;
            if (accept && ctl.upd)
                state_q <= nxt_state;
            else if (waiting && cph_done)
                state_q <= cph_dout;
        end
    end

    assign cmd_ready = !busy;
    assign cph_din   = state_q;

endmodule

// File: rtl/aead_mode_ctrl_chk.sv
module aead_mode_ctrl_chk #(
    parameter int STATE_W = 128
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic               busy,
    input logic               out_valid,
    input logic               tag_valid,
    input logic               cph_start,
    input logic               cph_done,
    input logic [STATE_W-1:0] cph_dout,
    input logic [STATE_W-1:0] state_q
);
    // R7: start is a single-cycle pulse
    a_r7_start_pulse: assert property (@(posedge clk) disable iff (rst)
        cph_start |=> !cph_start);

    // R7: start only follows an accepted command
    a_r7_start_after_accept: assert property (@(posedge clk) disable iff (rst)
        cph_start |-> $past(cmd_valid && cmd_ready));

    // R7/R8: input assumption, done arrives only while waiting
    a_r7_done_in_wait: assert property (@(posedge clk) disable iff (rst)
        cph_done |-> (busy && !cph_start));

    // R8: busy holds until done
    a_r8_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        (busy && !cph_done) |=> busy);

    // R8: state is frozen while busy and no result arrives
    a_r8_state_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && !cph_done) |=> $stable(state_q));

    // R9: result is taken into the state
    a_r9_result_loaded: assert property (@(posedge clk) disable iff (rst)
        (busy && cph_done) |=> (state_q == $past(cph_dout)));

    // R6: tag command starts no call
    a_r6_tag_no_call: assert property (@(posedge clk) disable iff (rst)
        tag_valid |-> (!busy && !cph_start));

    // R2/R5: output word only after an accepted command
    a_r2_out_after_accept: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(cmd_valid && cmd_ready));

    // R2/R6: never both output kinds at once
    a_r6_one_output: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && tag_valid));

endmodule

bind aead_mode_ctrl aead_mode_ctrl_chk #(.STATE_W(STATE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .busy     (busy),
    .out_valid(out_valid),
    .tag_valid(tag_valid),
    .cph_start(cph_start),
    .cph_done (cph_done),
    .cph_dout (cph_dout),
    .state_q  (state_q)
);

// File: tb/aead_mode_ctrl_test.sv
module aead_mode_ctrl_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic [2:0]   cmd_op = 3'd0;
    logic [63:0]  blk_in = '0;
    logic [119:0] nonce_in = '0;
    logic         cmd_ready, busy, out_valid, tag_valid, cph_start;
    logic [63:0]  out_data;
    logic [127:0] tag_out, cph_din;
    logic         cph_done = 1'b0;
    logic [127:0] cph_dout = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [127:0] model = '0;
    logic [63:0]  exp_out[$];
    logic [127:0] exp_tag[$];
    logic [127:0] exp_call[$];
    logic [63:0]  got_out[$];
    logic [127:0] got_tag[$];

    always #5 clk = ~clk;

    aead_mode_ctrl uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .blk_in(blk_in), .nonce_in(nonce_in), .cmd_ready(cmd_ready),
        .busy(busy), .out_valid(out_valid), .out_data(out_data),
        .tag_valid(tag_valid), .tag_out(tag_out), .cph_start(cph_start),
        .cph_din(cph_din), .cph_done(cph_done), .cph_dout(cph_dout)
    );

    function automatic logic [127:0] perm(input logic [127:0] x);
        return {x[114:0], x[127:115]} ^ 128'h3c5a_96e1_0f7b_d248_a51c_e3f0_6b29_874d;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: predicts results, queues them, presents one command
    task automatic issue(input logic [2:0] op, input logic [63:0] b, input logic [119:0] n);
        logic [127:0] nx;
        while (busy) @(negedge clk);
        nx = model;
        case (op)
            3'd1: begin exp_out.push_back(model[127:64] ^ b); nx[127:64] = model[127:64] ^ b; end
            3'd2: nx[127:64] = b;
            3'd3: nx = model ^ {n, 8'h01};
            3'd4: begin exp_out.push_back(model[127:64] ^ b); nx[127:64] = b; end
            3'd5: exp_tag.push_back(model);
            default: ;
        endcase
        if (op >= 3'd1 && op <= 3'd4) begin
            exp_call.push_back(nx);
            model = perm(nx);
        end
        cmd_valid = 1'b1; cmd_op = op; blk_in = b; nonce_in = n;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_reset();
        while (busy) @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = '0;
    endtask

    task automatic drain();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pops expected words and tags as they appear
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                got_out.push_back(out_data);
                if (exp_out.size() == 0) chk("R2/R5 unexpected out_valid", 128'(out_data), 128'hx);
                else chk("R2/R5 out_data", 128'(out_data), 128'(exp_out.pop_front()));
            end
            if (tag_valid) begin
                got_tag.push_back(tag_out);
                if (exp_tag.size() == 0) chk("R6 unexpected tag_valid", tag_out, 128'hx);
                else chk("R6 tag_out", tag_out, exp_tag.pop_front());
            end
        end
    end

    // Stand-in cipher: answers two cycles after each start
    initial begin
        logic [127:0] x;
        forever begin
            @(negedge clk);
            if (!rst && cph_start) begin
                x = cph_din;
                if (exp_call.size() == 0) chk("R7 unexpected cph_start", x, 128'hx);
                else chk("R7 cph_din", x, exp_call.pop_front());
                @(negedge clk);
                chk("R7 start one cycle", 128'(cph_start), 128'(0));
                @(negedge clk);
                cph_dout = perm(x);
                cph_done = 1'b1;
                @(negedge clk);
                cph_done = 1'b0;
            end
        end
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0]  m1, m2, c1, c2;
        logic [127:0] ta, tb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset values
        chk("R1 busy", 128'(busy), 128'(0));
        chk("R1 cmd_ready", 128'(cmd_ready), 128'(1));
        chk("R1 out_valid", 128'(out_valid), 128'(0));
        chk("R1 tag_valid", 128'(tag_valid), 128'(0));
        chk("R1 cph_start", 128'(cph_start), 128'(0));
        issue(3'd5, '0, '0);     // R1: tag of zero state
        drain();

        // R2 then R8: absorb, then a command while busy is ignored
        issue(3'd1, 64'h0123_4567_89ab_cdef, '0);
        chk("R8 busy after accept", 128'(busy), 128'(1));
        chk("R8 cmd_ready low", 128'(cmd_ready), 128'(0));
        cmd_valid = 1'b1; cmd_op = 3'd2; blk_in = 64'hffff_ffff_ffff_ffff;
        @(negedge clk);
        cmd_valid = 1'b0;
        issue(3'd5, '0, '0);     // R9/R8: state equals cipher result only
        drain();

        // R3: load with no feedback
        issue(3'd2, 64'hdead_beef_0bad_f00d, '0);
        issue(3'd5, '0, '0);
        drain();

        // R4: nonce with domain constant
        issue(3'd3, '0, 120'h11_2233_4455_6677_8899_aabb_ccdd_eeff);
        issue(3'd5, '0, '0);
        drain();

        // R5: ciphertext absorb
        issue(3'd4, 64'hfeed_face_cafe_babe, '0);
        issue(3'd1, 64'h0, '0);
        drain();

        // R10: undefined opcodes
        foreach (exp_tag[i]) ;
        for (int k = 0; k < 3; k++) begin
            issue((k == 0) ? 3'd0 : ((k == 1) ? 3'd6 : 3'd7), 64'haaaa_5555_aaaa_5555, 120'h1);
            chk("R10 no busy", 128'(busy), 128'(0));
            @(negedge clk);
            chk("R10 no output", 128'(out_valid | tag_valid | cph_start), 128'(0));
        end
        issue(3'd5, '0, '0);
        drain();

        // R6: two back-to-back tags, no call, same value
        issue(3'd5, '0, '0);
        chk("R6 no call", 128'(busy | cph_start), 128'(0));
        issue(3'd5, '0, '0);
        drain();

        // R11: encryption session
        m1 = 64'h5468_6520_7175_6963; m2 = 64'h6b20_6272_6f77_6e20;
        do_reset();
        issue(3'd3, '0, 120'hab_cdef_0123_4567_89ab_cdef_0123);
        got_out.delete(); got_tag.delete();
        issue(3'd1, m1, '0);
        issue(3'd1, m2, '0);
        issue(3'd5, '0, '0);
        drain();
        c1 = got_out[0]; c2 = got_out[1]; ta = got_tag[0];
        // R11: decryption session
        do_reset();
        issue(3'd3, '0, 120'hab_cdef_0123_4567_89ab_cdef_0123);
        got_out.delete(); got_tag.delete();
        issue(3'd4, c1, '0);
        issue(3'd4, c2, '0);
        issue(3'd5, '0, '0);
        drain();
        chk("R11 plaintext 1", 128'(got_out[0]), 128'(m1));
        chk("R11 plaintext 2", 128'(got_out[1]), 128'(m2));
        tb = got_tag[0];
        chk("R11 tag match", tb, ta);
        chk("R11 ciphertext differs", 128'(c1 != m1), 128'(1));

        chk("queues empty", 128'(exp_out.size() + exp_tag.size() + exp_call.size()), 128'(0));
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule